// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a compact 16-bit processor built around a single accumulator. Instructions and data share one external memory, which has a synchronous port: the address is sampled on a clock edge and the read word is available during the following cycle. Internally the block keeps a program counter, an instruction register, the accumulator, a memory address register and a memory buffer register. It steps through a fixed sequence of states for each instruction. Three are fetch states, then come decode, the operand read, the accumulator update or the memory write, and finally an interrupt check.

Each instruction word carries a 4-bit operation code above a 12-bit direct address. The operations are load, store, add, return-from-interrupt and halt. Every other code does nothing. Arithmetic uses sign-magnitude numbers: bit 15 is the sign and the low 15 bits are the magnitude.

The check state closes every instruction. If the request line is high and the enable flag is set, the block saves the address of the next instruction and clears the enable flag. It then sends the program counter to a fixed handler entry and pulses an acknowledge output. The return operation restores the saved address and sets the flag again.

The states are:
- FETCH_ADDR: PC is copied to the memory address register.
- FETCH_READ: the memory samples the address, and PC steps by one.
- FETCH_LATCH: the read word is captured into the instruction register.
- DECODE: the next state is chosen from the operation code.
- OPND_READ: the memory samples the operand address.
- OPND_LATCH: the operand is captured.
- ACC_UPDATE: load or add is applied to the accumulator.
- WRITE: the store takes place.
- IRQ_CHECK: the interrupt check is made.
- STOPPED: the block is halted.

The transitions are:
- FETCH_ADDR to FETCH_READ to FETCH_LATCH to DECODE.
- From DECODE:
  - load and add go to OPND_READ, then OPND_LATCH, then ACC_UPDATE, then IRQ_CHECK.
  - store goes to WRITE, then IRQ_CHECK.
  - return and the no-op codes go straight to IRQ_CHECK.
  - halt goes to STOPPED, which has no exit except reset.
- IRQ_CHECK always goes to FETCH_ADDR. It either enters the handler or simply continues.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word is split into an operation code in bits 15:12 and a direct memory address in bits 11:0.
- R2: After reset, the program counter is 0x300 and the first address presented to memory is 0x300. Each fetch reads the word at the program counter and then adds one to it, wrapping within 12 bits.
- R3: Operation code 0x1 copies the word at the instruction's address into the accumulator.
- R4: Operation code 0x2 writes the accumulator to the instruction's address. Write enable is high for exactly one cycle per store, and no other operation writes memory.
- R5: Operation code 0x5 adds the memory word to the accumulator in sign-magnitude form, with bit 15 as the sign:
  - With equal signs, the magnitudes are added and any carry out of 15 bits is dropped.
  - With different signs, the smaller magnitude is taken from the larger and the result takes the sign of the larger.
  - A zero result is always 0x0000.
- R6: After every executed instruction the block checks the request input. If it is high and the enable flag is set, the block does all of the following:
  - pulses the acknowledge output for one cycle
  - saves the address of the next instruction
  - clears the enable flag
  - continues fetching at 0x010
  Otherwise it fetches the next instruction.
- R7: The enable flag is set by reset. While the flag is clear, a high request is ignored and stays pending.
- R8: Operation code 0xF restores the saved address into the program counter and sets the enable flag. The check that follows can enter the handler again at once.
- R9: Operation code 0x0 stops the block. The halted output stays high and memory is not written again until reset.
- R10: Every other operation code has no effect: the accumulator and memory are unchanged, and execution continues with the next word.
- R11: A program at 0x300 that loads 0x940, adds 0x941 and stores to 0x941 leaves the sum in 0x941.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address (address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the address is sampled |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle pulse when the handler is entered |
| halted | output | 1 | High while the block is stopped |

## Verification
The return operation and a new handler entry can fall on the same boundary. The return sets the enable flag, and the check state right after it sees the still-pending request. The bench provokes this by keeping the request high until two acknowledges have arrived. The first request is taken after the first instruction. The second request stays pending through the whole handler and must be taken immediately after the return.

Each entry is judged from the order of the memory writes, which the bench compares against its instruction-level model on every clock, together with the acknowledge count. The final contents of memory are also judged against hand-computed values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_RET   = 4'hF;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_LATCH,
        ST_DECODE,
        ST_OPND_READ,
        ST_OPND_LATCH,
        ST_ACC_UPDATE,
        ST_WRITE,
        ST_IRQ_CHECK,
        ST_STOPPED
    } cpu_state_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic pc_inc;
        logic ir_load;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic ac_load;
        logic ac_add;
        logic mem_we;
        logic ret;
        logic irq_take;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    localparam int MAG_W = DATA_W - 1;

    logic             sign_a, sign_b, sign_r;
    logic [MAG_W-1:0] mag_a, mag_b, mag_r;

    assign sign_a = a[DATA_W-1];
    assign sign_b = b[DATA_W-1];
    assign mag_a  = a[MAG_W-1:0];
    assign mag_b  = b[MAG_W-1:0];

    always_comb begin
        if (sign_a == sign_b) begin
            mag_r  = mag_a + mag_b;
            sign_r = sign_a;
        end else if (mag_a >= mag_b) begin
            mag_r  = mag_a - mag_b;
            sign_r = sign_a;
        end else begin
            mag_r  = mag_b - mag_a;
            sign_r = sign_b;
        end
        if (mag_r == '0) begin
            sign_r = 1'b0;
        end
    end

    assign sum = {sign_r, mag_r};

endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq,
    input  logic             irq_en,
    output ctrl_t            ctrl,
    output logic             halted
);
    cpu_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_ADDR:  state_d = ST_FETCH_READ;
            ST_FETCH_READ:  state_d = ST_FETCH_LATCH;
            ST_FETCH_LATCH: state_d = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD,
                    OPC_ADD:   state_d = ST_OPND_READ;
                    OPC_STORE: state_d = ST_WRITE;
                    OPC_HALT:  state_d = ST_STOPPED;
                    default:   state_d = ST_IRQ_CHECK;
                endcase
            end
            ST_OPND_READ:   state_d = ST_OPND_LATCH;
            ST_OPND_LATCH:  state_d = ST_ACC_UPDATE;
            ST_ACC_UPDATE:  state_d = ST_IRQ_CHECK;
            ST_WRITE:       state_d = ST_IRQ_CHECK;
            ST_IRQ_CHECK:   state_d = ST_FETCH_ADDR;
            ST_STOPPED:     state_d = ST_STOPPED;
            default:        state_d = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        ctrl   = '0;
        halted = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR:  ctrl.mar_from_pc = 1'b1;
            ST_FETCH_READ:  ctrl.pc_inc = 1'b1;
            ST_FETCH_LATCH: begin
                ctrl.ir_load      = 1'b1;
                ctrl.mbr_from_mem = 1'b1;
            end
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD,
                    OPC_ADD:   ctrl.mar_from_ir = 1'b1;
                    OPC_STORE: begin
                        ctrl.mar_from_ir = 1'b1;
                        ctrl.mbr_from_ac = 1'b1;
                    end
                    OPC_RET:   ctrl.ret = 1'b1;
                    default:   ;
                endcase
            end
            ST_OPND_READ:   ;
            ST_OPND_LATCH:  ctrl.mbr_from_mem = 1'b1;
            ST_ACC_UPDATE: begin
                if (opcode == OPC_LOAD) ctrl.ac_load = 1'b1;
                else                    ctrl.ac_add  = 1'b1;
            end
            ST_WRITE:       ctrl.mem_we = 1'b1;
            ST_IRQ_CHECK:   ctrl.irq_take = irq && irq_en;
            ST_STOPPED:     halted = 1'b1;
            default:        ;
        endcase
    end

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !ctrl.mem_we);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_we |=> !ctrl.mem_we);

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] RESET_PC   = 'h300,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 'h010,
    localparam int              DATA_W     = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] sum,
    output logic [OPC_W-1:0]  opcode,
    output logic              irq_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ac,
    output logic [DATA_W-1:0] mbr
);
    logic [ADDR_W-1:0] pc_q, mar_q, ret_pc_q;
    logic [DATA_W-1:0] ir_q, ac_q, mbr_q;
    logic              ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            ret_pc_q <= RESET_PC;
            mar_q    <= '0;
            ir_q     <= '0;
            ac_q     <= '0;
            mbr_q    <= '0;
            ien_q    <= 1'b1;
        end else begin
            if (ctrl.irq_take)    pc_q <= HANDLER_PC;
            else if (ctrl.ret)    pc_q <= ret_pc_q;
            else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;

            if (ctrl.mar_from_pc)      mar_q <= pc_q;
            else if (ctrl.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];

            if (ctrl.mbr_from_mem)     mbr_q <= mem_rdata;
            else if (ctrl.mbr_from_ac) mbr_q <= ac_q;

            if (ctrl.ir_load) ir_q <= mem_rdata;

            if (ctrl.ac_load)     ac_q <= mbr_q;
            else if (ctrl.ac_add) ac_q <= sum;

            if (ctrl.irq_take) ret_pc_q <= pc_q;

            if (ctrl.irq_take) ien_q <= 1'b0;
            else if (ctrl.ret) ien_q <= 1'b1;
        end
    end

    assign opcode    = ir_q[DATA_W-1 -: OPC_W];
    assign irq_en    = ien_q;
    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign ac        = ac_q;
    assign mbr       = mbr_q;

    // R6
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.irq_take |=> (pc_q == HANDLER_PC) && !ien_q && (ret_pc_q == $past(pc_q)));

    // R8
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ret |=> (pc_q == $past(ret_pc_q)) && ien_q);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_inc |=> pc_q == $past(pc_q) + 1'b1);

    // R5
    no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ac_add |=> ac_q != {1'b1, {(DATA_W-1){1'b0}}});

    // R4
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_we |-> mbr_q == ac_q);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] RESET_PC   = 'h300,
    parameter logic [ADDR_W-1:0] HANDLER_PC = 'h010,
    localparam int              DATA_W     = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq,
    output logic              irq_ack,
    output logic              halted
);
    ctrl_t             ctrl;
    logic [OPC_W-1:0]  opcode;
    logic              irq_en;
    logic [DATA_W-1:0] ac, mbr, sum;

    acc_cpu_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .irq    (irq),
        .irq_en (irq_en),
        .ctrl   (ctrl),
        .halted (halted)
    );

    acc_cpu_datapath #(
        .ADDR_W     (ADDR_W),
        .RESET_PC   (RESET_PC),
        .HANDLER_PC (HANDLER_PC)
    ) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .sum       (sum),
        .opcode    (opcode),
        .irq_en    (irq_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ac        (ac),
        .mbr       (mbr)
    );

    acc_cpu_smadd #(
        .DATA_W (DATA_W)
    ) u_smadd (
        .a   (ac),
        .b   (mbr),
        .sum (sum)
    );

    assign mem_we  = ctrl.mem_we;
    assign irq_ack = ctrl.irq_take;

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq;
    logic        irq_ack;
    logic        halted;

    always #4 clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq),
        .irq_ack(irq_ack), .halted(halted)
    );

    logic [15:0] mem     [0:4095];
    logic [15:0] ref_mem [0:4095];
    int total = 0, bad = 0;
    int irq_want = 0, ack_cnt = 0, exp_acks = 0;
    int exp_wa[$], exp_wd[$];
    bit done = 0;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // request source: holds the line high until irq_want acknowledges arrive
    always @(posedge clk) begin
        if (!rst_n)       ack_cnt <= 0;
        else if (irq_ack) ack_cnt <= ack_cnt + 1;
    end
    assign irq = rst_n && (ack_cnt < irq_want);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // every-clock comparison of writes against the model's ordered list (R4, R9)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_wa.size() == 0) begin
                check(0, "R4", "unexpected write addr", int'(mem_addr), -1);
            end else begin
                check(mem_addr == exp_wa[0], "R4", "write addr", int'(mem_addr), exp_wa[0]);
                check(mem_wdata == exp_wd[0], "R4", "write data", int'(mem_wdata), exp_wd[0]);
                void'(exp_wa.pop_front());
                void'(exp_wd.pop_front());
            end
        end
    end

    function automatic logic [15:0] sm_add(input logic [15:0] x, input logic [15:0] y);
        int vx, vy, r, m;
        bit s;
        vx = x[15] ? -int'(x[14:0]) : int'(x[14:0]);
        vy = y[15] ? -int'(y[14:0]) : int'(y[14:0]);
        if (x[15] == y[15]) begin
            m = (int'(x[14:0]) + int'(y[14:0])) % 32768;
            s = x[15];
        end else begin
            r = vx + vy;
            m = (r < 0) ? -r : r;
            s = (r < 0);
        end
        if (m == 0) s = 0;
        return {s, 15'(m)};
    endfunction

    // instruction-level reference model
    task automatic run_model();
        int pc = 'h300, saved = 'h300, taken = 0;
        bit ie = 1;
        logic [15:0] acc = 0, w;
        for (int step = 0; step < 2000; step++) begin
            w  = ref_mem[pc];
            pc = (pc + 1) % 4096;
            case (w[15:12])
                4'h0: break;
                4'h1: acc = ref_mem[w[11:0]];
                4'h2: begin
                    ref_mem[w[11:0]] = acc;
                    exp_wa.push_back(int'(w[11:0]));
                    exp_wd.push_back(int'(acc));
                end
                4'h5: acc = sm_add(acc, ref_mem[w[11:0]]);
                4'hF: begin pc = saved; ie = 1; end
                default: ;
            endcase
            if (ie && taken < irq_want) begin
                saved = pc; pc = 'h010; ie = 0; taken++;
            end
        end
        exp_acks = taken;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic run_prog(input string name);
        int cyc = 0, diff = 0;
        rst_n = 0;
        exp_wa.delete(); exp_wd.delete();
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        run_model();
        repeat (3) @(negedge clk);
        check(halted == 0, "R9", {name, " halted in reset"}, int'(halted), 0);
        check(mem_we == 0, "R4", {name, " write in reset"}, int'(mem_we), 0);
        rst_n = 1;
        @(negedge clk);
        check(mem_addr == 12'h300, "R2", {name, " first fetch address"}, int'(mem_addr), 'h300);
        while (!halted && cyc < 20000) begin @(negedge clk); cyc++; end
        check(halted == 1, "R9", {name, " reached halt"}, int'(halted), 1);
        repeat (12) @(negedge clk);
        check(halted == 1, "R9", {name, " halt held"}, int'(halted), 1);
        check(exp_wa.size() == 0, "R4", {name, " missing writes"}, exp_wa.size(), 0);
        check(ack_cnt == exp_acks, "R6", {name, " ack count"}, ack_cnt, exp_acks);
        for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) diff++;
        check(diff == 0, "R10", {name, " memory image vs model"}, diff, 0);
    endtask

    initial begin
        // T1: sum program (R11, R3, R5, R1)
        clear_mem(); irq_want = 0;
        mem['h300] = 16'h1940; mem['h301] = 16'h5941;
        mem['h302] = 16'h2941; mem['h303] = 16'h0000;
        mem['h940] = 16'h0003; mem['h941] = 16'h0002;
        run_prog("sum");
        check(mem['h941] == 16'h0005, "R11", "sum at 0x941", int'(mem['h941]), 5);

        // T2: sign-magnitude cases, no-op codes (R5, R10, R3, R1)
        clear_mem(); irq_want = 0;
        begin
            logic [15:0] xa [7] = '{16'h0005, 16'h8005, 16'h0003, 16'h8004, 16'h7FFF, 16'h8000, 16'h0002};
            logic [15:0] xb [7] = '{16'h8003, 16'h0003, 16'h8003, 16'h8006, 16'h0001, 16'h8000, 16'h8007};
            logic [15:0] xr [7] = '{16'h0002, 16'h8002, 16'h0000, 16'h800A, 16'h0000, 16'h0000, 16'h8005};
            int p = 'h300;
            for (int k = 0; k < 7; k++) begin
                mem['hA00 + 2*k] = xa[k];
                mem['hA01 + 2*k] = xb[k];
                mem[p] = 16'h1000 | 16'(12'hA00 + 2*k); p++;
                mem[p] = 16'h5000 | 16'(12'hA01 + 2*k); p++;
                mem[p] = 16'h2000 | 16'(12'hB00 + k);   p++;
            end
            mem['h123] = 16'h4321;
            mem['hC00] = 16'h0042;
            mem[p] = 16'h1C00; p++;            // AC = 0x0042
            mem[p] = 16'h7123; p++;            // no-op code 0x7
            mem[p] = 16'h3123; p++;            // no-op code 0x3
            mem[p] = 16'h2C01; p++;            // store AC to 0xC01
            mem[p] = 16'h0000;
            run_prog("signs");
            for (int k = 0; k < 7; k++)
                check(mem['hB00 + k] == xr[k], "R5", $sformatf("case %0d", k),
                      int'(mem['hB00 + k]), int'(xr[k]));
            check(mem['hC01] == 16'h0042, "R10", "acc after no-op", int'(mem['hC01]), 'h42);
            check(mem['h123] == 16'h4321, "R10", "no-op target untouched", int'(mem['h123]), 'h4321);
        end

        // T3: two requests, second pending across the handler (R6, R7, R8)
        clear_mem(); irq_want = 2;
        mem['h300] = 16'h1940; mem['h301] = 16'h5941;
        mem['h302] = 16'h2942; mem['h303] = 16'h0000;
        mem['h940] = 16'h0007; mem['h941] = 16'h0001;
        mem['h010] = 16'h5061; mem['h011] = 16'h2062; mem['h012] = 16'hF000;
        mem['h061] = 16'h0001;
        run_prog("irq");
        check(mem['h062] == 16'h0009, "R8", "handler ran twice", int'(mem['h062]), 9);
        check(mem['h942] == 16'h000A, "R6", "main resumed", int'(mem['h942]), 'hA);
        check(ack_cnt == 2, "R7", "acks", ack_cnt, 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=running expected=halted");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule